// File: doc/BRIEF.md
# Dual-Bus Pipelined Data Access Unit

This block moves data between a small synchronous data memory and two register files, a set of address registers and a set of data registers. Each request is handled in three stages. In the first (address) stage, the block puts up to two read addresses on a primary and a secondary address bus. In the same stage it computes the post-modified or transferred address-register value and writes it back. In the second stage, the memory latches the addresses. In the third stage, read values come back on two separate read buses and are written into the destination registers. Write data leaves on its own bus in that same stage.

One request can enter per cycle. A request names up to two address registers (primary and secondary), a step, a destination for each read port and, for a store, the write data. Every in-flight access carries its valid bit, its direction and its destination indices down the pipeline, so each captured value lands in the register its request named. A request is held back when an older read that is still in flight will load an address register the request needs. A store followed at once by a load of the same word forwards the fresh data.

Top module: `dau_core`

## Requirements
- R1: After reset every address register and every data register reads zero, `req_ready` is high, and the address-valid, read-valid and write-enable outputs are low.
- R2: Operation codes are 0 none, 1 single read, 2 dual read, 3 write, 4 address add (`ar[pa] = ar[sa] + step`), 5 address transfer (`ar[pa] = ar[sa]`). In the cycle an accepted read or write is presented, `prim_addr` equals `ar[pa]` with `prim_vld` high. A dual read also drives `sec_addr = ar[sa]` with `sec_vld` high, and `sec_vld` is never high without `prim_vld`.
- R3: An accepted read or write adds `step` (modulo 2^6) to `ar[pa]`, and the very next request already sees the new value. `ar[sa]` is left unchanged.
- R4: Address add and address transfer update `ar[pa]` in the cycle they are accepted and drive no address, read or write bus.
- R5: Read data appears two cycles after the address stage, on `rdp_data` with `rdp_vld`, and for a dual read also on `rds_data` with `rds_vld`. A word never written holds (address*37+5) mod 2^16.
- R6: A read value is captured at the end of its data stage into the register its destination code names. Bit 2 set selects address register `code[1:0]`, which takes the low 6 bits. Bit 2 clear selects data register `code[1:0]`. When both destinations of a dual read are the same register, the secondary value is kept.
- R7: A write presents `wr_en`, `wr_addr = ar[pa]` and `wr_data` two cycles after its address stage, and the memory word holds that data from the next cycle on.
- R8: A read of a word issued in the cycle right after a write to that word returns the newly written data.
- R9: A request whose used address registers (`pa` for single read and write; `pa` and `sa` for dual read, add and transfer) are the address-register destination of a read in the latch or data stage sees `req_ready` low. While stalled it drives no address bus. It is stalled for two cycles when it directly follows that read and for one cycle when one cycle separates them.
- R10: A request that uses no address register loaded by an in-flight read is accepted with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation code |
| req_pa | input | 2 | Primary address register index |
| req_sa | input | 2 | Secondary address register index |
| req_step | input | 6 | Step or addend, modulo 2^6 |
| req_dp | input | 3 | Destination code for the primary read |
| req_ds | input | 3 | Destination code for the secondary read |
| req_wdata | input | 16 | Store data |
| req_ready | output | 1 | Request accepted this cycle when high |
| prim_addr | output | 6 | Primary address bus |
| prim_vld | output | 1 | Primary address valid |
| sec_addr | output | 6 | Secondary address bus |
| sec_vld | output | 1 | Secondary address valid |
| rdp_data | output | 16 | Primary read bus |
| rdp_vld | output | 1 | Primary read valid |
| rds_data | output | 16 | Secondary read bus |
| rds_vld | output | 1 | Secondary read valid |
| wr_addr | output | 6 | Write address |
| wr_data | output | 16 | Write data bus |
| wr_en | output | 1 | Write enable |
| dreg_flat | output | 64 | Data registers, register i at bits [16i+15:16i] |
| areg_flat | output | 24 | Address registers, register i at bits [6i+5:6i] |

## Verification
The latency properties assume that `req_op` stays within the six defined codes and that reset is held for at least one clock before traffic starts. The bench drives only those codes and only after reset. The stall-length property relies on no new read entering the pipeline while a request is held back. The bench keeps a stalled request on the inputs until `req_ready` rises, which also allows the number of stall cycles to be counted at the ports.

// File: rtl/dau_pkg.sv
package dau_pkg;

    localparam int AW       = 6;
    localparam int DW       = 16;
    localparam int NAR      = 4;
    localparam int NDR      = 4;
    localparam int IW       = $clog2(NAR);
    localparam int DSTW     = IW + 1;
    localparam int DEPTH    = 1 << AW;
    localparam int SEED_MUL = 37;
    localparam int SEED_ADD = 5;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_RD1  = 3'd1,
        OP_RD2  = 3'd2,
        OP_WR   = 3'd3,
        OP_ADDA = 3'd4,
        OP_TFR  = 3'd5
    } op_e;

    typedef struct packed {
        logic            vld;
        logic            rd;
        logic            dual;
        logic            wr;
        logic [DSTW-1:0] dp;
        logic [DSTW-1:0] ds;
        logic [AW-1:0]   ap;
        logic [AW-1:0]   as_;
        logic [DW-1:0]   wd;
    } stage_t;

    function automatic logic is_mem(op_e o);
        return (o == OP_RD1) || (o == OP_RD2) || (o == OP_WR);
    endfunction

    function automatic logic uses_p(op_e o);
        return is_mem(o) || (o == OP_ADDA) || (o == OP_TFR);
    endfunction

    function automatic logic uses_s(op_e o);
        return (o == OP_RD2) || (o == OP_ADDA) || (o == OP_TFR);
    endfunction

    function automatic logic loads_ar(stage_t s, logic [IW-1:0] idx);
        logic hit_p;
        logic hit_s;
        hit_p = s.dp[IW] && (s.dp[IW-1:0] == idx);
        hit_s = s.dual && s.ds[IW] && (s.ds[IW-1:0] == idx);
        return s.vld && s.rd && (hit_p || hit_s);
    endfunction

endpackage

// File: rtl/dau_rf.sv
module dau_rf #(
    parameter int W  = 16,
    parameter int N  = 4,
    parameter int IW = 2,
    parameter int NP = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NP-1:0]        we,
    input  logic [NP-1:0][IW-1:0] wi,
    input  logic [NP-1:0][W-1:0] wv,
    output logic [N*W-1:0]       flat
);

    logic [W-1:0] regs [N];

    // Higher-numbered ports win when indices collide.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else begin
            for (int p = 0; p < NP; p++) begin
                if (we[p]) regs[wi[p]] <= wv[p];
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_flat
        assign flat[g*W +: W] = regs[g];
    end

endmodule

// File: rtl/dau_agu.sv
module dau_agu
    import dau_pkg::*;
(
    input  logic              acc,
    input  op_e               op,
    input  logic [IW-1:0]     pa,
    input  logic [IW-1:0]     sa,
    input  logic [AW-1:0]     step,
    input  logic [NAR*AW-1:0] ar_flat,
    output logic [AW-1:0]     addr_p,
    output logic [AW-1:0]     addr_s,
    output logic              upd_en,
    output logic [IW-1:0]     upd_idx,
    output logic [AW-1:0]     upd_val
);

    assign addr_p  = ar_flat[pa*AW +: AW];
    assign addr_s  = ar_flat[sa*AW +: AW];
    assign upd_idx = pa;

    always_comb begin
        upd_en  = 1'b0;
        upd_val = addr_p;
        unique case (op)
            OP_RD1, OP_RD2, OP_WR: begin
                upd_en  = acc;
                upd_val = addr_p + step;
            end
            OP_ADDA: begin
                upd_en  = acc;
                upd_val = addr_s + step;
            end
            OP_TFR: begin
                upd_en  = acc;
                upd_val = addr_s;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dau_mem.sv
module dau_mem
    import dau_pkg::*;
#(
    parameter int MAW = AW,
    parameter int MDW = DW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           re,
    input  logic [MAW-1:0] ra_p,
    input  logic [MAW-1:0] ra_s,
    input  logic           we,
    input  logic [MAW-1:0] wa,
    input  logic [MDW-1:0] wd,
    output logic [MDW-1:0] q_p,
    output logic [MDW-1:0] q_s
);

    localparam int MDEPTH = 1 << MAW;

    logic [MDW-1:0] mem [MDEPTH];

    function automatic logic [MDW-1:0] seed(int a);
        return MDW'(a * SEED_MUL + SEED_ADD);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MDEPTH; i++) mem[i] <= seed(i);
        end else if (we) begin
            mem[wa] <= wd;
        end
    end

    // Write-first: a read latched on the same edge as a write sees the new data.
    always_ff @(posedge clk) begin
        if (rst) begin
            q_p <= '0;
            q_s <= '0;
        end else if (re) begin
            q_p <= (we && (wa == ra_p)) ? wd : mem[ra_p];
            q_s <= (we && (wa == ra_s)) ? wd : mem[ra_s];
        end
    end

endmodule

// File: rtl/dau_core.sv
module dau_core
    import dau_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [IW-1:0]     req_pa,
    input  logic [IW-1:0]     req_sa,
    input  logic [AW-1:0]     req_step,
    input  logic [DSTW-1:0]   req_dp,
    input  logic [DSTW-1:0]   req_ds,
    input  logic [DW-1:0]     req_wdata,
    output logic              req_ready,
    output logic [AW-1:0]     prim_addr,
    output logic              prim_vld,
    output logic [AW-1:0]     sec_addr,
    output logic              sec_vld,
    output logic [DW-1:0]     rdp_data,
    output logic              rdp_vld,
    output logic [DW-1:0]     rds_data,
    output logic              rds_vld,
    output logic [AW-1:0]     wr_addr,
    output logic [DW-1:0]     wr_data,
    output logic              wr_en,
    output logic [NDR*DW-1:0] dreg_flat,
    output logic [NAR*AW-1:0] areg_flat
);

    op_e            op;
    logic           haz;
    logic           acc;
    logic [AW-1:0]  addr_p;
    logic [AW-1:0]  addr_s;
    logic           upd_en;
    logic [IW-1:0]  upd_idx;
    logic [AW-1:0]  upd_val;
    stage_t         s1n;
    stage_t         s2;
    stage_t         s3;
    logic [DW-1:0]  q_p;
    logic [DW-1:0]  q_s;
    logic           cap_p;
    logic           cap_s;

    assign op = op_e'(req_op);

    // Hold back a request whose address registers an older read will still load.
    always_comb begin
        haz = 1'b0;
        if (uses_p(op) && (loads_ar(s2, req_pa) || loads_ar(s3, req_pa))) haz = 1'b1;
        if (uses_s(op) && (loads_ar(s2, req_sa) || loads_ar(s3, req_sa))) haz = 1'b1;
        haz = haz && req_valid;
    end

    assign acc       = req_valid && !haz;
    assign req_ready = !haz;

    dau_agu u_agu (
        .acc     (acc),
        .op      (op),
        .pa      (req_pa),
        .sa      (req_sa),
        .step    (req_step),
        .ar_flat (areg_flat),
        .addr_p  (addr_p),
        .addr_s  (addr_s),
        .upd_en  (upd_en),
        .upd_idx (upd_idx),
        .upd_val (upd_val)
    );

    // Address stage: build the record that travels with the access.
    always_comb begin
        s1n      = '0;
        s1n.vld  = acc && is_mem(op);
        s1n.rd   = (op == OP_RD1) || (op == OP_RD2);
        s1n.dual = (op == OP_RD2);
        s1n.wr   = (op == OP_WR);
        s1n.dp   = req_dp;
        s1n.ds   = req_ds;
        s1n.ap   = addr_p;
        s1n.as_  = addr_s;
        s1n.wd   = req_wdata;
    end

    assign prim_addr = addr_p;
    assign sec_addr  = addr_s;
    assign prim_vld  = s1n.vld;
    assign sec_vld   = s1n.vld && s1n.dual;

    // Latch stage, then data stage.
    always_ff @(posedge clk) begin
        if (rst) begin
            s2 <= '0;
            s3 <= '0;
        end else begin
            s2 <= s1n;
            s3 <= s2;
        end
    end

    dau_mem u_mem (
        .clk  (clk),
        .rst  (rst),
        .re   (s2.vld && s2.rd),
        .ra_p (s2.ap),
        .ra_s (s2.as_),
        .we   (wr_en),
        .wa   (wr_addr),
        .wd   (wr_data),
        .q_p  (q_p),
        .q_s  (q_s)
    );

    assign rdp_data = q_p;
    assign rds_data = q_s;
    assign cap_p    = s3.vld && s3.rd;
    assign cap_s    = s3.vld && s3.dual;
    assign rdp_vld  = cap_p;
    assign rds_vld  = cap_s;
    assign wr_en    = s3.vld && s3.wr;
    assign wr_addr  = s3.ap;
    assign wr_data  = s3.wd;

    // Port 0: primary capture, port 1: secondary capture, port 2: address-stage update.
    dau_rf #(.W(AW), .N(NAR), .IW(IW), .NP(3)) u_arf (
        .clk  (clk),
        .rst  (rst),
        .we   ({upd_en, cap_s && s3.ds[IW], cap_p && s3.dp[IW]}),
        .wi   ({upd_idx, s3.ds[IW-1:0], s3.dp[IW-1:0]}),
        .wv   ({upd_val, q_s[AW-1:0], q_p[AW-1:0]}),
        .flat (areg_flat)
    );

    dau_rf #(.W(DW), .N(NDR), .IW(IW), .NP(3)) u_drf (
        .clk  (clk),
        .rst  (rst),
        .we   ({1'b0, cap_s && !s3.ds[IW], cap_p && !s3.dp[IW]}),
        .wi   ({{IW{1'b0}}, s3.ds[IW-1:0], s3.dp[IW-1:0]}),
        .wv   ({{DW{1'b0}}, q_s, q_p}),
        .flat (dreg_flat)
    );

endmodule

// File: rtl/dau_core_chk.sv
module dau_core_chk
    import dau_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic [2:0]    req_op,
    input logic          req_ready,
    input logic          prim_vld,
    input logic [AW-1:0] prim_addr,
    input logic          sec_vld,
    input logic          rdp_vld,
    input logic          rds_vld,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr
);

    logic rd_issue;
    logic wr_issue;
    logic arith_req;

    assign rd_issue  = prim_vld && ((req_op == OP_RD1) || (req_op == OP_RD2));
    assign wr_issue  = prim_vld && (req_op == OP_WR);
    assign arith_req = req_valid && ((req_op == OP_ADDA) || (req_op == OP_TFR));

    p_sec_needs_prim_r2: assert property (@(posedge clk) disable iff (rst)
        sec_vld |-> prim_vld);

    p_arith_no_bus_r4: assert property (@(posedge clk) disable iff (rst)
        arith_req |-> !prim_vld && !sec_vld);

    p_read_latency_r5: assert property (@(posedge clk) disable iff (rst)
        rd_issue |-> ##2 rdp_vld);

    p_dual_latency_r5: assert property (@(posedge clk) disable iff (rst)
        sec_vld |-> ##2 rds_vld);

    p_write_latency_r7: assert property (@(posedge clk) disable iff (rst)
        wr_issue |-> ##2 (wr_en && (wr_addr == $past(prim_addr, 2))));

    p_stall_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> req_valid && !prim_vld);

    p_stall_bounded_r9: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !$past(req_ready)) |=> req_ready);

endmodule

bind dau_core dau_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_ready (req_ready),
    .prim_vld  (prim_vld),
    .prim_addr (prim_addr),
    .sec_vld   (sec_vld),
    .rdp_vld   (rdp_vld),
    .rds_vld   (rds_vld),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr)
);

// File: tb/dau_core_test.sv
module dau_core_test;
    import dau_pkg::*;

    localparam int CLK_P = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [2:0]        req_op = '0;
    logic [IW-1:0]     req_pa = '0;
    logic [IW-1:0]     req_sa = '0;
    logic [AW-1:0]     req_step = '0;
    logic [DSTW-1:0]   req_dp = '0;
    logic [DSTW-1:0]   req_ds = '0;
    logic [DW-1:0]     req_wdata = '0;
    logic              req_ready;
    logic [AW-1:0]     prim_addr;
    logic              prim_vld;
    logic [AW-1:0]     sec_addr;
    logic              sec_vld;
    logic [DW-1:0]     rdp_data;
    logic              rdp_vld;
    logic [DW-1:0]     rds_data;
    logic              rds_vld;
    logic [AW-1:0]     wr_addr;
    logic [DW-1:0]     wr_data;
    logic              wr_en;
    logic [NDR*DW-1:0] dreg_flat;
    logic [NAR*AW-1:0] areg_flat;

    always #(CLK_P/2) clk = ~clk;

    dau_core uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_pa(req_pa), .req_sa(req_sa), .req_step(req_step),
        .req_dp(req_dp), .req_ds(req_ds), .req_wdata(req_wdata),
        .req_ready(req_ready), .prim_addr(prim_addr), .prim_vld(prim_vld),
        .sec_addr(sec_addr), .sec_vld(sec_vld), .rdp_data(rdp_data),
        .rdp_vld(rdp_vld), .rds_data(rds_data), .rds_vld(rds_vld),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
        .dreg_flat(dreg_flat), .areg_flat(areg_flat)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // Sequential reference state.
    logic [AW-1:0] ar_m [NAR];
    logic [DW-1:0] dr_m [NDR];
    logic [DW-1:0] mem_m [DEPTH];
    logic [AW-1:0] e_pa, e_sa;
    logic [DW-1:0] e_rp, e_rs;

    typedef struct packed {
        logic [2:0]      op;
        logic [IW-1:0]   pa;
        logic [IW-1:0]   sa;
        logic [AW-1:0]   step;
        logic [DSTW-1:0] dp;
        logic [DSTW-1:0] ds;
        logic [DW-1:0]   wd;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{3'd4, 2'd0, 2'd0, 6'd5,  3'd0, 3'd0, 16'h0000},
        '{3'd4, 2'd1, 2'd0, 6'd9,  3'd0, 3'd0, 16'h0000},
        '{3'd1, 2'd0, 2'd0, 6'd1,  3'd0, 3'd0, 16'h0000},
        '{3'd2, 2'd0, 2'd1, 6'd2,  3'd1, 3'd2, 16'h0000},
        '{3'd3, 2'd1, 2'd0, 6'd63, 3'd0, 3'd0, 16'hBEEF},
        '{3'd4, 2'd1, 2'd1, 6'd1,  3'd0, 3'd0, 16'h0000},
        '{3'd1, 2'd1, 2'd0, 6'd0,  3'd3, 3'd0, 16'h0000},
        '{3'd5, 2'd2, 2'd0, 6'd0,  3'd0, 3'd0, 16'h0000},
        '{3'd1, 2'd2, 2'd0, 6'd0,  3'd7, 3'd0, 16'h0000},
        '{3'd2, 2'd3, 2'd2, 6'd0,  3'd0, 3'd0, 16'h0000},
        '{3'd1, 2'd0, 2'd0, 6'd60, 3'd1, 3'd0, 16'h0000},
        '{3'd2, 2'd0, 2'd3, 6'd0,  3'd5, 3'd6, 16'h0000}
    };

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [NAR*AW-1:0] ar_pack();
        logic [NAR*AW-1:0] v;
        for (int i = 0; i < NAR; i++) v[i*AW +: AW] = ar_m[i];
        return v;
    endfunction

    function automatic logic [NDR*DW-1:0] dr_pack();
        logic [NDR*DW-1:0] v;
        for (int i = 0; i < NDR; i++) v[i*DW +: DW] = dr_m[i];
        return v;
    endfunction

    task automatic put(logic [DSTW-1:0] d, logic [DW-1:0] v);
        if (d[IW]) ar_m[d[IW-1:0]] = v[AW-1:0];
        else       dr_m[d[IW-1:0]] = v;
    endtask

    task automatic model(vec_t t);
        e_pa = ar_m[t.pa];
        e_sa = ar_m[t.sa];
        e_rp = mem_m[e_pa];
        e_rs = mem_m[e_sa];
        case (t.op)
            3'd1: begin ar_m[t.pa] = e_pa + t.step; put(t.dp, e_rp); end
            3'd2: begin ar_m[t.pa] = e_pa + t.step; put(t.dp, e_rp); put(t.ds, e_rs); end
            3'd3: begin mem_m[e_pa] = t.wd; ar_m[t.pa] = e_pa + t.step; end
            3'd4: ar_m[t.pa] = e_sa + t.step;
            3'd5: ar_m[t.pa] = e_sa;
            default: ;
        endcase
    endtask

    // Present a request at a negedge, wait out any stall, check the address stage.
    task automatic drive(vec_t t, output int stalls);
        @(negedge clk);
        req_valid = 1'b1; req_op = t.op; req_pa = t.pa; req_sa = t.sa;
        req_step = t.step; req_dp = t.dp; req_ds = t.ds; req_wdata = t.wd;
        #1;
        stalls = 0;
        while (!req_ready && stalls < 8) begin
            chk("R9 no address bus while stalled", {62'd0, prim_vld, sec_vld}, 64'd0);
            stalls++;
            @(negedge clk);
            #1;
        end
        model(t);
        if (t.op == 3'd1 || t.op == 3'd2 || t.op == 3'd3) begin
            chk("R2 primary address", {63'd0, prim_vld} << AW | 64'(prim_addr),
                {63'd1} << AW | 64'(e_pa));
            chk("R2 secondary valid", {63'd0, sec_vld}, {63'd0, t.op == 3'd2});
            if (t.op == 3'd2) chk("R2 secondary address", 64'(sec_addr), 64'(e_sa));
        end else begin
            chk("R4 no bus for address arithmetic", {62'd0, prim_vld, sec_vld}, 64'd0);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int st;
        vec_t t;
        logic [DW-1:0] fwd;
        for (int i = 0; i < NAR; i++) ar_m[i] = '0;
        for (int i = 0; i < NDR; i++) dr_m[i] = '0;
        for (int i = 0; i < DEPTH; i++) mem_m[i] = DW'(i * 37 + 5);

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1 ready after reset", {63'd0, req_ready}, 64'd1);
        chk("R1 outputs idle", {60'd0, prim_vld, sec_vld, rdp_vld, wr_en}, 64'd0);
        chk("R1 address registers zero", 64'(areg_flat), 64'd0);
        chk("R1 data registers zero", 64'(dreg_flat), 64'd0);

        // Table walk: one request at a time, fully drained.
        for (int k = 0; k < NV; k++) begin
            t = TBL[k];
            drive(t, st);
            chk("R10 no stall when independent", 64'(st), 64'd0);
            idle();
            @(negedge clk); #1;
            if (t.op == 3'd1 || t.op == 3'd2) begin
                chk("R5 primary read data", {47'd0, rdp_vld, rdp_data}, {47'd1, e_rp});
                if (t.op == 3'd2)
                    chk("R5 secondary read data", {47'd0, rds_vld, rds_data}, {47'd1, e_rs});
            end else if (t.op == 3'd3) begin
                chk("R7 write bus", {41'd0, wr_en, wr_addr, wr_data},
                    {41'd1, e_pa, t.wd});
            end else begin
                chk("R4 no read or write", {62'd0, rdp_vld, wr_en}, 64'd0);
            end
            @(negedge clk); #1;
            chk("R6 address registers after capture", 64'(areg_flat), 64'(ar_pack()));
            chk("R6 data registers after capture", dreg_flat, dr_pack());
        end

        // R3: back-to-back requests see the post-modified register.
        drive('{3'd1, 2'd1, 2'd0, 6'd3, 3'd0, 3'd0, 16'h0}, st);
        drive('{3'd1, 2'd1, 2'd0, 6'd0, 3'd1, 3'd0, 16'h0}, st);
        chk("R3 no stall on post-modify chain", 64'(st), 64'd0);
        idle(); idle(); idle(); #1;
        chk("R3 address registers", 64'(areg_flat), 64'(ar_pack()));
        chk("R3 data registers", dreg_flat, dr_pack());

        // R8: write then immediate read of the same word.
        drive('{3'd3, 2'd2, 2'd0, 6'd0, 3'd0, 3'd0, 16'h1234}, st);
        drive('{3'd1, 2'd2, 2'd0, 6'd0, 3'd2, 3'd0, 16'h0}, st);
        fwd = e_rp;
        idle();
        @(negedge clk); #1;
        chk("R8 forwarded write data", {47'd0, rdp_vld, rdp_data}, {47'd1, 16'h1234});
        chk("R8 reference agrees", 64'(fwd), 64'h1234);
        @(negedge clk); #1;
        chk("R8 captured value", dreg_flat, dr_pack());

        // R9: read loading ar1, directly followed by a user of ar1.
        drive('{3'd1, 2'd0, 2'd0, 6'd0, 3'd5, 3'd0, 16'h0}, st);
        drive('{3'd1, 2'd1, 2'd0, 6'd1, 3'd3, 3'd0, 16'h0}, st);
        chk("R9 stall length adjacent", 64'(st), 64'd2);
        idle(); idle(); idle(); #1;
        chk("R9 registers after stall", 64'(areg_flat), 64'(ar_pack()));
        chk("R9 data after stall", dreg_flat, dr_pack());

        // R9: one idle cycle in between leaves a single stall cycle.
        drive('{3'd1, 2'd0, 2'd0, 6'd0, 3'd6, 3'd0, 16'h0}, st);
        idle();
        drive('{3'd4, 2'd0, 2'd2, 6'd1, 3'd0, 3'd0, 16'h0}, st);
        chk("R9 stall length separated", 64'(st), 64'd1);
        idle(); idle(); idle(); #1;
        chk("R9 add after stall", 64'(areg_flat), 64'(ar_pack()));

        // R10: a read into ar3 followed by a user of other registers.
        drive('{3'd1, 2'd0, 2'd0, 6'd0, 3'd7, 3'd0, 16'h0}, st);
        drive('{3'd2, 2'd1, 2'd2, 6'd2, 3'd0, 3'd1, 16'h0}, st);
        chk("R10 independent dual read", 64'(st), 64'd0);
        idle(); idle(); idle(); #1;
        chk("R10 address registers", 64'(areg_flat), 64'(ar_pack()));
        chk("R10 data registers", dreg_flat, dr_pack());

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule